// File: doc/BRIEF.md
# Interval Timer Alarm Generator

This block counts pulses from one of four slow time bases and raises an alarm once a programmed number of pulses has been seen. The time bases arrive as single-cycle enables on the fast system clock. A 2-bit source code picks one of them, and each selected pulse advances an 8-bit counter. When the advanced count reaches the programmed interval, the block pulses an alarm event for one cycle and sets a sticky alarm flag.

A mode bit chooses what happens after a match. With the bit clear, the counter restarts from zero and the alarm repeats at a fixed period. With the bit set, the alarm fires once and the counter is held at zero until software intervenes.

Control writes (enable, mode bit, source code) and interval writes come from a bus. They land in a shadow copy first. A separate 128 Hz enable, `slow_tick`, moves them through a staging copy into the active copy, so a write takes effect only after the second slow pulse.

Top module: `ivl_alarm_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises: `cnt_val` is 0, `alarm_evt` is 0, `alarm_flag` is 0, and the active configuration is disabled with interval 0.
- R2: A control write (`ctl_wr`) or interval write (`intv_wr`) first updates a shadow copy. Each `slow_tick` copies the shadow into a staging copy and the staging copy into the active copy. A write therefore acts on the counter only after the second `slow_tick` pulse strictly after the write cycle; one pulse is not enough.
- R3: While the active enable is 0, `cnt_val` is 0 on the next cycle, no alarm is raised, and any hold is cleared.
- R4: Source code 0 selects `base_tick[0]` (1/128 s), 1 selects `base_tick[1]` (1 s), 2 selects `base_tick[2]` (1 min) and 3 selects `base_tick[3]` (1 h). Pulses on the other three bits leave the counter unchanged.
- R5: Each selected pulse replaces `cnt_val` with `cnt_val+1` modulo 256. If that value equals the active interval, `alarm_evt` is 1 for exactly one cycle and `cnt_val` becomes 0 instead. An interval of 0 therefore alarms on every 256th pulse.
- R6: With the active mode bit at 0, counting resumes from 0 after an alarm, and further alarms follow every interval-many pulses.
- R7: With the active mode bit at 1, after an alarm the counter is held at 0 and selected pulses are ignored. The hold ends when the enable goes to 0 or when a control write lands.
- R8: In the cycle where a control write becomes active (on the second `slow_tick`), the counter is cleared to 0 and any hold is released. An interval-only write does not clear the counter.
- R9: `alarm_flag` sets with each alarm and stays set until `flag_clr` is 1 in a cycle with no alarm. An alarm in the same cycle as `flag_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 4 | Time-base pulse enables, bit n used by source code n |
| slow_tick | input | 1 | 128 Hz enable that advances configuration capture |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Written enable bit |
| ctl_oneshot | input | 1 | Written mode bit (1 = hold after alarm) |
| ctl_sel | input | 2 | Written time-base source code |
| intv_wr | input | 1 | Interval write strobe |
| intv_val | input | 8 | Written interval value |
| flag_clr | input | 1 | Write-1 clear of the alarm flag |
| cnt_val | output | 8 | Current counter value |
| alarm_evt | output | 1 | One-cycle pulse per alarm |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The hardest states to reach from the ports are two collisions. The first is an alarm in the same cycle as a flag clear. The second is a control write landing while the counter is held after a one-shot alarm. Directed sequences stage each collision: they count the pulses up to one short of the interval and then issue the clear, or they rewrite the control word and supply the two slow pulses. A long random phase then mixes writes (including writes in the same cycle as slow pulses), sparse ticks on all four bases and random clears. A bench model of the shadow, staging and active copies predicts every cycle.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic             en;
    logic             oneshot;
    logic [SEL_W-1:0] sel;
  } ivl_ctl_t;
endpackage

// File: rtl/ivl_cfg_sync.sv
module ivl_cfg_sync #(
  parameter int CTL_W = 4,
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_d,
  input  logic             val_wr,
  input  logic [VAL_W-1:0] val_d,
  output logic [CTL_W-1:0] ctl_q,
  output logic [VAL_W-1:0] val_q,
  output logic             ctl_land
);
  logic [CTL_W-1:0] ctl_sh, ctl_st;
  logic [VAL_W-1:0] val_sh, val_st;
  logic             sh_new, st_new;

  assign ctl_land = slow_tick && st_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_sh <= '0;
      ctl_st <= '0;
      ctl_q  <= '0;
      val_sh <= '0;
      val_st <= '0;
      val_q  <= '0;
      sh_new <= 1'b0;
      st_new <= 1'b0;
    end else begin
      if (ctl_wr) ctl_sh <= ctl_d;
      if (val_wr) val_sh <= val_d;
      if (ctl_wr)         sh_new <= 1'b1;
      else if (slow_tick) sh_new <= 1'b0;
      if (slow_tick) begin
        ctl_st <= ctl_sh;
        val_st <= val_sh;
        st_new <= sh_new;
        ctl_q  <= ctl_st;
        val_q  <= val_st;
      end
    end
  end
endmodule

// File: rtl/ivl_tick_mux.sv
module ivl_tick_mux #(
  parameter int SEL_W = 2,
  localparam int NBASE = 1 << SEL_W
) (
  input  logic [NBASE-1:0] ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  assign tick = ticks[sel];
endmodule

// File: rtl/ivl_counter.sv
module ivl_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             oneshot,
  input  logic             tick,
  input  logic             land,
  input  logic [CNT_W-1:0] intv,
  output logic [CNT_W-1:0] cnt,
  output logic             hold,
  output logic             hit
);
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic is_match(input logic [CNT_W-1:0] nxt,
                                    input logic [CNT_W-1:0] limit);
    return nxt == limit;
  endfunction

  logic [CNT_W-1:0] nxt;
  logic             advance;

  assign nxt     = cnt_step(cnt);
  assign advance = en && !land && !hold && tick;
  assign hit     = advance && is_match(nxt, intv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= 1'b0;
    end else if (!en || land) begin
      cnt  <= '0;
      hold <= 1'b0;
    end else if (hold) begin
      cnt  <= '0;
    end else if (tick) begin
      if (hit) begin
        cnt  <= '0;
        hold <= oneshot;
      end else begin
        cnt  <= nxt;
      end
    end
  end
endmodule

// File: rtl/ivl_alarm_timer.sv
module ivl_alarm_timer #(
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               base_tick,
  input  logic                     slow_tick,
  input  logic                     ctl_wr,
  input  logic                     ctl_en,
  input  logic                     ctl_oneshot,
  input  logic [ivl_pkg::SEL_W-1:0] ctl_sel,
  input  logic                     intv_wr,
  input  logic [CNT_W-1:0]         intv_val,
  input  logic                     flag_clr,
  output logic [CNT_W-1:0]         cnt_val,
  output logic                     alarm_evt,
  output logic                     alarm_flag
);
  import ivl_pkg::*;
  localparam int CTL_W = $bits(ivl_ctl_t);

  ivl_ctl_t         ctl_wdata, ctl_act;
  logic [CTL_W-1:0] ctl_act_vec;
  logic [CNT_W-1:0] intv_act;
  logic             cfg_land;
  logic             sel_tick;
  logic             hold_q;
  logic             alarm_hit;
  logic             en_act;

  assign ctl_wdata = '{en: ctl_en, oneshot: ctl_oneshot, sel: ctl_sel};
  assign ctl_act   = ivl_ctl_t'(ctl_act_vec);
  assign en_act    = ctl_act.en;

  ivl_cfg_sync #(.CTL_W(CTL_W), .VAL_W(CNT_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .ctl_wr   (ctl_wr),
    .ctl_d    (ctl_wdata),
    .val_wr   (intv_wr),
    .val_d    (intv_val),
    .ctl_q    (ctl_act_vec),
    .val_q    (intv_act),
    .ctl_land (cfg_land)
  );

  ivl_tick_mux #(.SEL_W(SEL_W)) u_mux (
    .ticks(base_tick),
    .sel  (ctl_act.sel),
    .tick (sel_tick)
  );

  ivl_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_act),
    .oneshot(ctl_act.oneshot),
    .tick   (sel_tick),
    .land   (cfg_land),
    .intv   (intv_act),
    .cnt    (cnt_val),
    .hold   (hold_q),
    .hit    (alarm_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_evt  <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      alarm_evt <= alarm_hit;
      if (alarm_hit)     alarm_flag <= 1'b1;
      else if (flag_clr) alarm_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ivl_alarm_chk.sv
module ivl_alarm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_act,
  input logic             sel_tick,
  input logic             cfg_land,
  input logic             hold_q,
  input logic             alarm_hit,
  input logic             flag_clr,
  input logic [CNT_W-1:0] cnt_val,
  input logic             alarm_evt,
  input logic             alarm_flag
);
  // R3
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |=> (cnt_val == '0) && !alarm_evt);

  // R5
  evt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> cnt_val == '0);

  // R9
  evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> alarm_flag);

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !alarm_hit |=> !alarm_flag);

  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_act && hold_q && !cfg_land |=> (cnt_val == '0) && !alarm_evt);

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_act && !sel_tick && !cfg_land |=> $stable(cnt_val));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_act && sel_tick && !hold_q && !cfg_land && !alarm_hit
      |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1));

  // R8
  land_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_land |=> (cnt_val == '0) && !hold_q);
endmodule

bind ivl_alarm_timer ivl_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_act    (en_act),
  .sel_tick  (sel_tick),
  .cfg_land  (cfg_land),
  .hold_q    (hold_q),
  .alarm_hit (alarm_hit),
  .flag_clr  (flag_clr),
  .cnt_val   (cnt_val),
  .alarm_evt (alarm_evt),
  .alarm_flag(alarm_flag)
);

// File: tb/ivl_alarm_timer_tb.sv
module ivl_alarm_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] base_tick = '0;
  logic       slow_tick = 1'b0;
  logic       ctl_wr = 1'b0, ctl_en = 1'b0, ctl_oneshot = 1'b0;
  logic [1:0] ctl_sel = '0;
  logic       intv_wr = 1'b0;
  logic [7:0] intv_val = '0;
  logic       flag_clr = 1'b0;
  logic [7:0] cnt_val;
  logic       alarm_evt, alarm_flag;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur = "R1";

  // bench model of the configuration path and counter
  logic [3:0] m_sh_ctl = '0, m_st_ctl = '0, m_ctl = '0; // {en, oneshot, sel}
  logic [7:0] m_sh_iv = '0, m_st_iv = '0, m_iv = '0;
  logic       m_sh_new = 0, m_st_new = 0;
  logic [7:0] m_cnt = '0;
  logic       m_hold = 0, m_flag = 0, m_evt = 0;

  always #4 clk = ~clk;

  ivl_alarm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .slow_tick(slow_tick),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_oneshot(ctl_oneshot), .ctl_sel(ctl_sel),
    .intv_wr(intv_wr), .intv_val(intv_val), .flag_clr(flag_clr),
    .cnt_val(cnt_val), .alarm_evt(alarm_evt), .alarm_flag(alarm_flag)
  );

  function automatic logic [7:0] wrap_inc(input logic [7:0] c);
    return 8'((int'(c) + 1) % 256);
  endfunction

  function automatic logic pick(input logic [3:0] bt, input logic [1:0] code);
    case (code)
      2'd0: return bt[0];
      2'd1: return bt[1];
      2'd2: return bt[2];
      default: return bt[3];
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic land, en, os, tk;
    logic [7:0] n;
    land = slow_tick && m_st_new;
    en = m_ctl[3]; os = m_ctl[2];
    tk = pick(base_tick, m_ctl[1:0]);
    m_evt = 0;
    if (!en || land) begin
      m_cnt = 0; m_hold = 0;
    end else if (m_hold) begin
      m_cnt = 0;
    end else if (tk) begin
      n = wrap_inc(m_cnt);
      if (n == m_iv) begin m_evt = 1; m_cnt = 0; m_hold = os; end
      else m_cnt = n;
    end
    if (m_evt) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    if (slow_tick) begin
      m_ctl = m_st_ctl; m_iv = m_st_iv;
      m_st_ctl = m_sh_ctl; m_st_iv = m_sh_iv; m_st_new = m_sh_new;
    end
    if (ctl_wr) m_sh_new = 1;
    else if (slow_tick) m_sh_new = 0;
    if (ctl_wr) m_sh_ctl = {ctl_en, ctl_oneshot, ctl_sel};
    if (intv_wr) m_sh_iv = intv_val;
  endtask

  task automatic cyc(input logic [3:0] bt, input logic slow, input logic clr);
    @(negedge clk);
    base_tick = bt; slow_tick = slow; flag_clr = clr;
    @(posedge clk);
    model_step();
    #2;
    check(cur, "cnt_val", cnt_val, m_cnt);
    check(cur, "alarm_evt", alarm_evt, m_evt);
    check(cur, "alarm_flag", alarm_flag, m_flag);
    ctl_wr = 0; intv_wr = 0;
  endtask

  task automatic wr_ctl(input logic en, input logic os, input logic [1:0] sel);
    ctl_wr = 1; ctl_en = en; ctl_oneshot = os; ctl_sel = sel;
  endtask

  task automatic wr_intv(input logic [7:0] v);
    intv_wr = 1; intv_val = v;
  endtask

  task automatic land_cfg();
    cyc(4'h0, 1, 0);
    cyc(4'h0, 1, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    // R1: reset state
    cur = "R1";
    repeat (3) @(posedge clk);
    #2;
    check("R1", "cnt_val in reset", cnt_val, 0);
    check("R1", "alarm_evt in reset", alarm_evt, 0);
    check("R1", "alarm_flag in reset", alarm_flag, 0);
    @(negedge clk); rst_n = 1;
    cyc(4'hF, 0, 0);
    check("R1", "disabled after reset", cnt_val, 0);

    // R2: one slow pulse is not enough
    cur = "R2";
    wr_ctl(1, 0, 2'd1); wr_intv(8'd3);
    cyc(4'h0, 0, 0);
    cyc(4'h0, 1, 0);
    repeat (3) cyc(4'hF, 0, 0);
    check("R2", "no count after one slow pulse", cnt_val, 0);
    cyc(4'h0, 1, 0);
    cyc(4'b0010, 0, 0);
    check("R2", "counts after second slow pulse", cnt_val, 1);

    // R4: unselected bases ignored
    cur = "R4";
    repeat (4) cyc(4'b1101, 0, 0);
    check("R4", "other bases ignored", cnt_val, 1);
    cyc(4'b0010, 0, 0);
    check("R4", "selected base counts", cnt_val, 2);

    // R5: match at interval
    cur = "R5";
    cyc(4'b0010, 0, 0);
    check("R5", "alarm pulse", alarm_evt, 1);
    check("R5", "counter back to zero", cnt_val, 0);
    cyc(4'h0, 0, 0);
    check("R5", "alarm single cycle", alarm_evt, 0);

    // R9: clear, then clear colliding with alarm
    cur = "R9";
    cyc(4'h0, 0, 1);
    check("R9", "flag cleared", alarm_flag, 0);
    cyc(4'b0010, 0, 0); cyc(4'b0010, 0, 0);
    cyc(4'b0010, 0, 1);
    check("R9", "alarm wins over clear", alarm_flag, 1);

    // R6: periodic restart
    cur = "R6";
    for (int i = 0; i < 9; i++) cyc(4'b0010, 0, 0);
    check("R6", "third period alarm", alarm_evt, 1);

    // R7: one-shot hold, R8: landing releases it
    cur = "R7";
    wr_ctl(1, 1, 2'd3);
    cyc(4'h0, 0, 0);
    cur = "R8";
    cyc(4'b1000, 0, 0);
    cyc(4'b1000, 1, 0);
    cyc(4'b1000, 0, 0);
    cyc(4'b1000, 1, 0);
    check("R8", "land clears counter", cnt_val, 0);
    cur = "R7";
    for (int i = 0; i < 3; i++) cyc(4'b1000, 0, 0);
    check("R7", "one-shot alarm", alarm_evt, 1);
    for (int i = 0; i < 5; i++) cyc(4'b1000, 0, 0);
    check("R7", "held at zero", cnt_val, 0);
    check("R7", "no repeat alarm", alarm_evt, 0);
    cur = "R8";
    wr_intv(8'd5);
    cyc(4'h0, 0, 0); land_cfg();
    cyc(4'b1000, 0, 0);
    check("R8", "interval write keeps hold", cnt_val, 0);
    wr_ctl(1, 1, 2'd3);
    cyc(4'h0, 0, 0); land_cfg();
    cyc(4'b1000, 0, 0);
    check("R8", "control write releases hold", cnt_val, 1);

    // R3: disable
    cur = "R3";
    wr_ctl(0, 0, 2'd0);
    cyc(4'h0, 0, 0); land_cfg();
    for (int i = 0; i < 4; i++) cyc(4'hF, 0, 0);
    check("R3", "disabled counter zero", cnt_val, 0);

    // R5: interval 0 means 256 pulses
    cur = "R5";
    wr_ctl(1, 0, 2'd0); wr_intv(8'd0);
    cyc(4'h0, 0, 0); land_cfg();
    for (int i = 0; i < 255; i++) cyc(4'b0001, 0, 0);
    check("R5", "255 pulses at interval 0", cnt_val, 255);
    check("R5", "no alarm before 256", alarm_evt, 0);
    cyc(4'b0001, 0, 0);
    check("R5", "alarm at 256 pulses", alarm_evt, 1);

    // random mix
    cur = "R5";
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] bt;
      if ($urandom_range(0, 19) == 0)
        wr_ctl($urandom_range(0, 5) != 0, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
      if ($urandom_range(0, 29) == 0) wr_intv(8'($urandom_range(0, 7)));
      for (int b = 0; b < 4; b++) bt[b] = ($urandom_range(0, 2) == 0);
      cyc(bt, $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0);
    end

    finish_run();
  end
endmodule